// File: doc/BRIEF.md
# Little-Endian Load/Store Byte-Lane Unit

This block sits between a 32-bit register file and a byte-addressable data memory that is 32 bits wide. It receives the 32-bit memory instruction, the base register value, the value to be stored and the word that memory returns. From these it forms the effective address, aligns that address down to the containing word, and places store data in the correct byte lanes with a matching byte-enable mask. On a load, it selects the addressed byte, half-word or word from the returned word and sign-extends or zero-extends it to 32 bits.

The whole path is combinational and runs in one cycle. Memory timing is left to the surrounding pipeline. An access that does not sit on its natural boundary is not split into two memory cycles. Instead, the unit raises a flag and blocks every side effect. Lane placement is little-endian: byte lane k of the memory word carries data bits 8k+7 down to 8k, and lane k holds the byte whose address ends in k.

Top module: `lsu_byte_lane`

## Requirements
- R1: The effective address is the base value plus the 12-bit offset sign-extended to 32 bits. `mem_addr` is that address with its two low bits forced to zero, and the lane is the address's two low bits.
- R2: The opcode sits in instruction bits 6:0: 0000011 is a load and 0100011 is a store. The width code sits in bits 14:12. A store takes its offset from bits 31:25 (upper seven) joined with bits 11:7 (lower five). A load takes its offset from bits 31:20.
- R3: A byte store (width code 000) drives `mem_be` = 0001 shifted left by the lane and repeats the low byte of `store_val` in all four lanes.
- R4: A half store (001) drives `mem_be` = 0011 shifted left by twice the upper lane bit and repeats the low half of `store_val` in both halves. A word store (010) drives 1111 with `store_val` unchanged.
- R5: A byte load returns the byte in the addressed lane. Code 000 sign-extends it and code 100 zero-extends it.
- R6: A half load returns the half selected by the upper lane bit. Code 001 sign-extends it and code 101 zero-extends it.
- R7: A word load (010) returns `mem_rdata` unchanged.
- R8: A half access with an odd address, or a word access whose address is not a multiple of four, sets `misaligned`. It also forces `mem_be` to 0000 and `load_val` to zero.
- R9: The unit treats three cases as no access: an opcode that is neither load nor store, a store width code outside {000,001,010}, and a load width code outside {000,001,010,100,101}. For these it drives `mem_be` 0000, `load_val` zero and `misaligned` low.
- R10: A load never drives a nonzero `mem_be`, and a store always returns `load_val` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Memory instruction word (opcode, width code, offset fields) |
| base_val | input | 32 | Base register value |
| store_val | input | 32 | Register value to be stored |
| mem_rdata | input | 32 | Word returned by memory for the current address |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane write enables, bit k for lane k |
| mem_wdata | output | 32 | Lane-replicated write data |
| load_val | output | 32 | Extracted and extended load result |
| misaligned | output | 1 | Access crosses its natural alignment |

## Verification
The corner cases the bench targets are these:
- **Negative offsets and carries across the word boundary.** A design that zero-extended the offset would point far above the base.
- **The split store offset.** Taking the store offset from the load field would land on the wrong word.
- **Each of the four lanes, on a known word.** Big-endian placement would return reversed bytes.
- **Bytes and halves with the top bit set, under both signed and unsigned codes.** A swapped extension would show up in the upper bits.
- **Every misaligned lane for half and word accesses, and the unsupported width codes.** A design that leaked enables here would corrupt memory.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    localparam int OFF_W = 12;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    localparam logic [2:0] SZ_B  = 3'b000;
    localparam logic [2:0] SZ_H  = 3'b001;
    localparam logic [2:0] SZ_W  = 3'b010;
    localparam logic [2:0] SZ_BU = 3'b100;
    localparam logic [2:0] SZ_HU = 3'b101;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic               legal;
        logic [2:0]         width;
        logic [OFF_W-1:0]   offset;
    } mem_req_t;

    function automatic acc_kind_e kind_of(input logic [6:0] opc);
        if (opc == OPC_LOAD)
            return ACC_LOAD;
        else if (opc == OPC_STORE)
            return ACC_STORE;
        return ACC_NONE;
    endfunction

    function automatic logic width_legal(input acc_kind_e k, input logic [2:0] w);
        logic ok;
        ok = 1'b0;
        case (k)
            ACC_STORE: ok = (w == SZ_B) || (w == SZ_H) || (w == SZ_W);
            ACC_LOAD:  ok = (w == SZ_B) || (w == SZ_H) || (w == SZ_W) ||
                            (w == SZ_BU) || (w == SZ_HU);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

    // size class from the two low bits of the width code: 0 byte, 1 half, 2 word
    function automatic logic off_boundary(input logic [2:0] w, input logic [1:0] lane);
        logic bad;
        case (w[1:0])
            2'b01:   bad = lane[0];
            2'b10:   bad = |lane;
            default: bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/lsu_insn_decode.sv
module lsu_insn_decode
    import lsu_lane_pkg::*;
(
    input  logic [31:0] instr,
    output mem_req_t    req
);
    acc_kind_e kind;
    logic      unused_fields;

    assign kind          = kind_of(instr[6:0]);
    assign unused_fields = ^instr[24:15];

    always_comb begin
        req.kind  = kind;
        req.width = instr[14:12];
        req.legal = width_legal(kind, instr[14:12]);
        if (kind == ACC_STORE)
            req.offset = {instr[31:25], instr[11:7]};
        else
            req.offset = instr[31:20];
    end

    always_comb begin
        if (req.legal) begin
            a_r9_legal_needs_kind: assert (req.kind != ACC_NONE);
        end
    end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_lane_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [XLEN-1:0]   base,
    input  logic [OFF_W-1:0]  offset,
    output logic [XLEN-1:0]   word_addr,
    output logic [LANE_W-1:0] lane
);
    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] eff;

    assign off_ext   = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
    assign eff       = base + off_ext;
    assign word_addr = {eff[XLEN-1:LANE_W], {LANE_W{1'b0}}};
    assign lane      = eff[LANE_W-1:0];
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_lane_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              en,
    input  logic [2:0]        width,
    input  logic [LANE_W-1:0] lane,
    input  logic [XLEN-1:0]   store_val,
    output logic [LANES-1:0]  be,
    output logic [XLEN-1:0]   wdata
);
    localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
    localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

    logic [LANE_W-1:0] half_shift;
    assign half_shift = {lane[LANE_W-1:1], 1'b0};

    always_comb begin
        case (width[1:0])
            2'b00:   wdata = {LANES{store_val[7:0]}};
            2'b01:   wdata = {(LANES/2){store_val[15:0]}};
            default: wdata = store_val;
        endcase
    end

    always_comb begin
        be = '0;
        if (en) begin
            case (width[1:0])
                2'b00:   be = ONE_LANE << lane;
                2'b01:   be = TWO_LANE << half_shift;
                default: be = '1;
            endcase
        end
    end

    always_comb begin
        if (!en) begin
            a_r8_idle_no_enable: assert (be == '0);
        end else begin
            a_r3_enable_count: assert ($countones(be) == 1 || $countones(be) == 2 ||
                                       $countones(be) == LANES);
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              en,
    input  logic [2:0]        width,
    input  logic [LANE_W-1:0] lane,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   value
);
    logic [7:0]  lane_byte [LANES];
    logic [15:0] lane_half [LANES/2];

    for (genvar gi = 0; gi < LANES; gi++) begin : g_bytes
        assign lane_byte[gi] = rdata[8*gi +: 8];
    end
    for (genvar gh = 0; gh < LANES/2; gh++) begin : g_halves
        assign lane_half[gh] = rdata[16*gh +: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    logic        sign_on;

    assign sel_b   = lane_byte[lane];
    assign sel_h   = lane_half[lane[LANE_W-1:1]];
    assign sign_on = ~width[2];

    always_comb begin
        value = '0;
        if (en) begin
            case (width[1:0])
                2'b00:   value = {{(XLEN-8){sign_on & sel_b[7]}}, sel_b};
                2'b01:   value = {{(XLEN-16){sign_on & sel_h[15]}}, sel_h};
                default: value = rdata;
            endcase
        end
    end

    always_comb begin
        if (en && width == SZ_B) begin
            a_r5_byte_sign_fill: assert (value[XLEN-1:8] == {(XLEN-8){value[7]}});
        end
        if (en && width == SZ_HU) begin
            a_r6_half_zero_fill: assert (value[XLEN-1:16] == '0);
        end
        if (!en) begin
            a_r9_idle_zero: assert (value == '0);
        end
    end
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
    import lsu_lane_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int LANES  = XLEN / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  base_val,
    input  logic [XLEN-1:0]  store_val,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  mem_addr,
    output logic [LANES-1:0] mem_be,
    output logic [XLEN-1:0]  mem_wdata,
    output logic [XLEN-1:0]  load_val,
    output logic             misaligned
);
    mem_req_t          req;
    logic [LANE_W-1:0] lane;
    logic              live;
    logic              st_en;
    logic              ld_en;

    lsu_insn_decode u_dec (
        .instr (instr),
        .req   (req)
    );

    lsu_addr_gen #(.XLEN(XLEN)) u_agen (
        .base      (base_val),
        .offset    (req.offset),
        .word_addr (mem_addr),
        .lane      (lane)
    );

    assign live       = req.legal && (req.kind != ACC_NONE);
    assign misaligned = live && off_boundary(req.width, lane[1:0]);
    assign st_en      = live && !misaligned && (req.kind == ACC_STORE);
    assign ld_en      = live && !misaligned && (req.kind == ACC_LOAD);

    lsu_store_lane #(.XLEN(XLEN)) u_st (
        .en        (st_en),
        .width     (req.width),
        .lane      (lane),
        .store_val (store_val),
        .be        (mem_be),
        .wdata     (mem_wdata)
    );

    lsu_load_extract #(.XLEN(XLEN)) u_ld (
        .en    (ld_en),
        .width (req.width),
        .lane  (lane),
        .rdata (mem_rdata),
        .value (load_val)
    );

    always_comb begin
        if (misaligned) begin
            a_r8_misaligned_quiet: assert (mem_be == '0 && load_val == '0);
        end
        if (req.kind == ACC_LOAD) begin
            a_r10_load_no_write: assert (mem_be == '0);
        end
        if (req.kind == ACC_STORE) begin
            a_r10_store_no_result: assert (load_val == '0);
        end
        a_r1_word_aligned: assert (mem_addr[LANE_W-1:0] == '0);
    end
endmodule

// File: tb/lsu_byte_lane_test.sv
module lsu_byte_lane_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] instr = '0, base_val = '0, store_val = '0, mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata, load_val;
    logic [3:0]  mem_be;
    logic        misaligned;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_byte_lane uut (
        .instr(instr), .base_val(base_val), .store_val(store_val),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .load_val(load_val), .misaligned(misaligned)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h instr=%h base=%h", tag, act, exp, instr, base_val);
        end
    endtask

    function automatic logic [31:0] mk_ld(input logic [11:0] imm, input logic [2:0] f3);
        return {imm, 5'd1, f3, 5'd2, 7'b0000011};
    endfunction

    function automatic logic [31:0] mk_st(input logic [11:0] imm, input logic [2:0] f3);
        return {imm[11:5], 5'd3, 5'd1, f3, imm[4:0], 7'b0100011};
    endfunction

    task automatic apply_and_check(input logic [31:0] ins, input logic [31:0] b,
                                   input logic [31:0] sv, input logic [31:0] rd);
        logic        is_ld, is_st, legal, mis;
        logic [11:0] imm;
        logic [31:0] ea, e_ld, e_wd;
        logic [3:0]  e_be;
        logic [1:0]  ln;
        logic [2:0]  f3;
        logic [7:0]  by;
        logic [15:0] hf;
        @(posedge clk);
        instr = ins; base_val = b; store_val = sv; mem_rdata = rd;
        @(negedge clk);
        f3    = ins[14:12];
        is_ld = (ins[6:0] == 7'b0000011);
        is_st = (ins[6:0] == 7'b0100011);
        imm   = is_st ? {ins[31:25], ins[11:7]} : ins[31:20];
        ea    = b + {{20{imm[11]}}, imm};
        ln    = ea[1:0];
        legal = is_st ? (f3 <= 3'd2) :
                is_ld ? (f3 <= 3'd2 || f3 == 3'd4 || f3 == 3'd5) : 1'b0;
        mis   = legal && ((f3[1:0] == 2'b01 && ln[0]) || (f3[1:0] == 2'b10 && ln != 2'b00));
        e_be = 4'b0000; e_wd = '0; e_ld = '0;
        by = rd[8*ln +: 8];
        hf = ln[1] ? rd[31:16] : rd[15:0];
        if (legal && !mis && is_st) begin
            case (f3)
                3'd0: begin e_be = 4'b0001 << ln; e_wd = {4{sv[7:0]}}; end
                3'd1: begin e_be = ln[1] ? 4'b1100 : 4'b0011; e_wd = {2{sv[15:0]}}; end
                default: begin e_be = 4'b1111; e_wd = sv; end
            endcase
        end
        if (legal && !mis && is_ld) begin
            case (f3)
                3'd0: e_ld = {{24{by[7]}}, by};
                3'd4: e_ld = {24'd0, by};
                3'd1: e_ld = {{16{hf[15]}}, hf};
                3'd5: e_ld = {16'd0, hf};
                default: e_ld = rd;
            endcase
        end
        if (is_ld || is_st) chk("R1 addr", mem_addr, {ea[31:2], 2'b00});
        if (!legal) chk("R9 be", {28'd0, mem_be}, 32'd0);
        else if (mis) chk("R8 be", {28'd0, mem_be}, 32'd0);
        else if (is_ld) chk("R10 be", {28'd0, mem_be}, 32'd0);
        else if (f3 == 3'd0) chk("R3 be", {28'd0, mem_be}, {28'd0, e_be});
        else chk("R4 be", {28'd0, mem_be}, {28'd0, e_be});
        if (e_be != 4'b0000) chk(f3 == 3'd0 ? "R3 wdata" : "R4 wdata", mem_wdata, e_wd);
        if (is_ld && legal && !mis)
            chk(f3[1:0] == 2'b00 ? "R5 load" : f3[1:0] == 2'b01 ? "R6 load" : "R7 load",
                load_val, e_ld);
        else
            chk(is_st ? "R10 load" : mis ? "R8 load" : "R9 load", load_val, e_ld);
        chk(mis ? "R8 flag" : "R9 flag", {31'd0, misaligned}, {31'd0, mis});
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        @(negedge clk);
        chk("R9 reset be", {28'd0, mem_be}, 32'd0);
        chk("R9 reset flag", {31'd0, misaligned}, 32'd0);

        // R5: lane placement on a known word, signed and unsigned byte loads
        for (int k = 0; k < 4; k++) begin
            apply_and_check(mk_ld(12'(k), 3'd0), 32'h000A0000, '0, 32'hABCD0123);
            apply_and_check(mk_ld(12'(k), 3'd4), 32'h000A0000, '0, 32'hABCD0123);
        end
        // R6/R7: halves and word
        apply_and_check(mk_ld(12'd2, 3'd1), 32'h000A0000, '0, 32'hABCD0123);
        apply_and_check(mk_ld(12'd2, 3'd5), 32'h000A0000, '0, 32'hABCD0123);
        apply_and_check(mk_ld(12'd0, 3'd1), 32'h000A0000, '0, 32'h00008001);
        apply_and_check(mk_ld(12'd0, 3'd2), 32'h000A0000, '0, 32'hABCD0123);
        // R1/R2: negative offsets, load and split store field
        apply_and_check(mk_ld(12'hFFC, 3'd2), 32'h00000100, '0, 32'h12345678);
        apply_and_check(mk_st(12'hFFF, 3'd0), 32'h00000100, 32'h000000A5, '0);
        apply_and_check(mk_st(12'h7E3, 3'd0), 32'h10000000, 32'h0000005A, '0);
        // R3/R4: store lanes
        for (int k = 0; k < 4; k++)
            apply_and_check(mk_st(12'(k), 3'd0), 32'h2000, 32'hCAFEBABE, '0);
        apply_and_check(mk_st(12'd2, 3'd1), 32'h2000, 32'hCAFEBABE, '0);
        apply_and_check(mk_st(12'd0, 3'd1), 32'h2000, 32'hCAFEBABE, '0);
        apply_and_check(mk_st(12'd8, 3'd2), 32'h2000, 32'hCAFEBABE, '0);
        // R8: every misaligned lane
        apply_and_check(mk_st(12'd1, 3'd1), 32'h2000, 32'h1111, '0);
        apply_and_check(mk_st(12'd3, 3'd1), 32'h2000, 32'h1111, '0);
        apply_and_check(mk_ld(12'd1, 3'd5), 32'h2000, '0, 32'hFFFFFFFF);
        for (int k = 1; k < 4; k++) begin
            apply_and_check(mk_st(12'(k), 3'd2), 32'h2000, 32'h1111, '0);
            apply_and_check(mk_ld(12'(k), 3'd2), 32'h2000, '0, 32'hFFFFFFFF);
        end
        // R9: unsupported codes and non-memory opcode
        apply_and_check(mk_st(12'd0, 3'd4), 32'h2000, 32'h1111, '0);
        apply_and_check(mk_ld(12'd0, 3'd3), 32'h2000, '0, 32'hFFFFFFFF);
        apply_and_check(mk_ld(12'd0, 3'd6), 32'h2000, '0, 32'hFFFFFFFF);
        apply_and_check(32'h00B50533, 32'h2000, 32'h1111, 32'hFFFFFFFF);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ins;
            logic [2:0]  f3;
            logic [11:0] imm;
            int          pick;
            pick = $urandom_range(0, 9);
            f3   = (pick < 8) ? 3'($urandom_range(0, 5)) : 3'($urandom_range(0, 7));
            imm  = 12'($urandom);
            if (pick < 4) ins = mk_ld(imm, f3);
            else if (pick < 8) ins = mk_st(imm, f3);
            else ins = $urandom;
            apply_and_check(ins, $urandom, $urandom, $urandom);
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule